// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control core of a small 16-bit, word-addressed processor. It steps each instruction through a gate cycle, a fetch, a decode cycle and, where needed, one or two data accesses. An eight-entry register file and a three-bit condition code live inside it. All traffic goes through one single-port memory request with a ready handshake. The core covers three operate instructions, loads and stores in three addressing modes, address generation and a halt word.

After reset the program counter holds the value on the start address input. By default the core runs freely. When the single-step mode input is high, it waits before each instruction for a one-cycle step request, which makes a program easy to walk through while debugging.

Top module: `seq16_core`

## Requirements
- R1: While reset is low, and in the first cycle after it, `pc_out` equals `start_addr`, `halted` is 0, `nzp` is 3'b010 and `mem_en` is 0. Reset clears all eight registers to zero.
- R2: Each instruction is fetched by a read at `pc_out`. The PC increments by one when that read completes, before the instruction executes. Successive instructions are fetched from consecutive addresses.
- R3: The opcode sits in bits [15:12], the destination in [11:9] and the first source in [8:6]. Opcodes 0001 (add) and 0101 (bitwise and) take their second operand from bit [5]: when it is 1, bits [4:0] are sign-extended; when it is 0, the register named by [2:0] is used. Opcode 1001 writes the bitwise complement of the first source.
- R4: Opcodes 0010 (load), 0011 (store) and 1110 (address load) form an address from the incremented PC plus bits [8:0] sign-extended. Opcode 1110 writes that address to the destination without any memory access.
- R5: Opcodes 0110 (load) and 0111 (store) form an address from the register in [8:6] plus bits [5:0] sign-extended.
- R6: Opcode 1010 reads a pointer at the PC-relative address and then reads the operand at that pointer. Opcode 1011 reads the pointer and then writes the register in [11:9] to it. The two accesses occur in that order.
- R7: Every register write updates `nzp`, with N in bit 2, Z in bit 1 and P in bit 0, to the sign of the written value. Exactly one bit is set. Stores leave `nzp` unchanged.
- R8: Once `mem_en` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle in which `mem_ready` is high. The access completes in that cycle.
- R9: The word xF025 makes `halted` go high and stay high until reset. No further memory request is made after it.
- R10: With `step_mode` high, no fetch begins until `step_req` is seen high in the gate cycle. Each such request runs exactly one instruction, so the PC advances by one.
- R11: The program LEA, ADD, ST, AND, ADD, STR, LDI placed at x30F6 and single-stepped leaves PC at x30FD. The value 5 then sits in R3, which a following store writes to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 16 | Value loaded into the PC at reset |
| step_mode | input | 1 | High: one instruction per step request |
| step_req | input | 1 | Step request, sampled in the gate cycle |
| mem_en | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Word address of the request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current request |
| halted | output | 1 | High after the halt word |
| pc_out | output | 16 | Current program counter |
| nzp | output | 3 | Condition code {N,Z,P} |

## Verification
The bench uses the default parameters: a halt word of xF025 and eight 16-bit registers. With these, both the free-running test program and the single-stepped sample program behave as a real program would. The memory model gives each access 0 to 2 wait cycles in rotation. Fetches, pointer reads and operand accesses therefore complete after different stall lengths, which exercises the request-hold rule and the order of the two accesses in an indirect instruction. Negative immediates and offsets, the zero flag, and pointer targets far outside the 9-bit range are all driven with these settings.

// File: rtl/seq16_pkg.sv
package seq16_pkg;

    localparam int unsigned XLEN    = 16;
    localparam int unsigned NREGS   = 8;
    localparam int unsigned RIDX_W  = $clog2(NREGS);

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0001,
        OP_AND  = 4'b0101,
        OP_NOT  = 4'b1001,
        OP_LD   = 4'b0010,
        OP_ST   = 4'b0011,
        OP_LDI  = 4'b1010,
        OP_STI  = 4'b1011,
        OP_LDR  = 4'b0110,
        OP_STR  = 4'b0111,
        OP_LEA  = 4'b1110,
        OP_TRAP = 4'b1111
    } op_e;

    typedef enum logic [2:0] {
        ST_GATE,
        ST_FETCH,
        ST_DECODE,
        ST_PTR,
        ST_LOAD,
        ST_STORE,
        ST_STOP
    } state_e;

    typedef struct packed {
        state_e     st;
        word_t      pc;
        word_t      ir;
        word_t      addr;
        logic [2:0] nzp;
    } ctl_t;

    function automatic word_t sext5(input logic [4:0] v);
        return {{(XLEN-5){v[4]}}, v};
    endfunction

    function automatic word_t sext6(input logic [5:0] v);
        return {{(XLEN-6){v[5]}}, v};
    endfunction

    function automatic word_t sext9(input logic [8:0] v);
        return {{(XLEN-9){v[8]}}, v};
    endfunction

    function automatic logic [2:0] sign_code(input word_t v);
        logic zero;
        zero = (v == '0);
        return {v[XLEN-1], zero, ~v[XLEN-1] & ~zero};
    endfunction

endpackage

// File: rtl/seq16_regfile.sv
module seq16_regfile #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] regs_d [DEPTH];
    logic [WIDTH-1:0] regs_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[g] <= '0;
                end else begin
                    regs_q[g] <= regs_d[g];
                end
            end
        end
    endgenerate

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    // R3
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && raddr_a == waddr) |=> (rdata_a == $past(wdata)));

endmodule

// File: rtl/seq16_alu.sv
module seq16_alu
    import seq16_pkg::*;
(
    input  op_e        op,
    input  logic       imm_sel,
    input  logic [4:0] imm5,
    input  word_t      src_a,
    input  word_t      src_b,
    output word_t      result
);

    word_t operand_b;

    always_comb begin
        operand_b = imm_sel ? sext5(imm5) : src_b;
        case (op)
            OP_ADD:  result = src_a + operand_b;
            OP_AND:  result = src_a & operand_b;
            OP_NOT:  result = ~src_a;
            default: result = src_a;
        endcase
    end

endmodule

// File: rtl/seq16_agen.sv
module seq16_agen
    import seq16_pkg::*;
(
    input  word_t      pc_inc,
    input  word_t      base,
    input  logic [8:0] off9,
    input  logic [5:0] off6,
    output word_t      pc_rel,
    output word_t      base_rel
);

    assign pc_rel   = pc_inc + sext9(off9);
    assign base_rel = base + sext6(off6);

endmodule

// File: rtl/seq16_core.sv
module seq16_core
    import seq16_pkg::*;
#(
    parameter logic [15:0] HALT_WORD = 16'hF025
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] start_addr,
    input  logic        step_mode,
    input  logic        step_req,
    output logic        mem_en,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ready,
    output logic        halted,
    output logic [15:0] pc_out,
    output logic [2:0]  nzp
);

    ctl_t cur_q, nxt_d;

    op_e               op;
    logic              is_store;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    word_t             rf_wdata;
    logic [RIDX_W-1:0] rb_idx;
    word_t             rd_a, rd_b;
    word_t             alu_res;
    word_t             pc_rel, base_rel;

    assign op       = op_e'(cur_q.ir[15:12]);
    assign is_store = (op == OP_ST) || (op == OP_STR) || (op == OP_STI);
    assign rb_idx   = is_store ? cur_q.ir[11:9] : cur_q.ir[2:0];
    assign rf_waddr = cur_q.ir[11:9];

    seq16_regfile #(
        .WIDTH (XLEN),
        .DEPTH (NREGS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (cur_q.ir[8:6]),
        .rdata_a (rd_a),
        .raddr_b (rb_idx),
        .rdata_b (rd_b)
    );

    seq16_alu u_alu (
        .op      (op),
        .imm_sel (cur_q.ir[5]),
        .imm5    (cur_q.ir[4:0]),
        .src_a   (rd_a),
        .src_b   (rd_b),
        .result  (alu_res)
    );

    seq16_agen u_agen (
        .pc_inc   (cur_q.pc),
        .base     (rd_a),
        .off9     (cur_q.ir[8:0]),
        .off6     (cur_q.ir[5:0]),
        .pc_rel   (pc_rel),
        .base_rel (base_rel)
    );

    always_comb begin
        nxt_d     = cur_q;
        rf_we     = 1'b0;
        rf_wdata  = '0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q.addr;
        mem_wdata = rd_b;

        case (cur_q.st)
            ST_GATE: begin
                if (!step_mode || step_req) begin
                    nxt_d.st = ST_FETCH;
                end
            end

            ST_FETCH: begin
                mem_en   = 1'b1;
                mem_addr = cur_q.pc;
                if (mem_ready) begin
                    nxt_d.ir = mem_rdata;
                    nxt_d.pc = cur_q.pc + 16'd1;
                    nxt_d.st = ST_DECODE;
                end
            end

            ST_DECODE: begin
                nxt_d.st = ST_GATE;
                case (op)
                    OP_ADD, OP_AND, OP_NOT: begin
                        rf_we     = 1'b1;
                        rf_wdata  = alu_res;
                        nxt_d.nzp = sign_code(alu_res);
                    end
                    OP_LEA: begin
                        rf_we     = 1'b1;
                        rf_wdata  = pc_rel;
                        nxt_d.nzp = sign_code(pc_rel);
                    end
                    OP_LD: begin
                        nxt_d.addr = pc_rel;
                        nxt_d.st   = ST_LOAD;
                    end
                    OP_LDR: begin
                        nxt_d.addr = base_rel;
                        nxt_d.st   = ST_LOAD;
                    end
                    OP_ST: begin
                        nxt_d.addr = pc_rel;
                        nxt_d.st   = ST_STORE;
                    end
                    OP_STR: begin
                        nxt_d.addr = base_rel;
                        nxt_d.st   = ST_STORE;
                    end
                    OP_LDI, OP_STI: begin
                        nxt_d.addr = pc_rel;
                        nxt_d.st   = ST_PTR;
                    end
                    OP_TRAP: begin
                        if (cur_q.ir == HALT_WORD) begin
                            nxt_d.st = ST_STOP;
                        end
                    end
                    default: begin
                        nxt_d.st = ST_GATE;
                    end
                endcase
            end

            ST_PTR: begin
                mem_en = 1'b1;
                if (mem_ready) begin
                    nxt_d.addr = mem_rdata;
                    nxt_d.st   = (op == OP_LDI) ? ST_LOAD : ST_STORE;
                end
            end

            ST_LOAD: begin
                mem_en = 1'b1;
                if (mem_ready) begin
                    rf_we     = 1'b1;
                    rf_wdata  = mem_rdata;
                    nxt_d.nzp = sign_code(mem_rdata);
                    nxt_d.st  = ST_GATE;
                end
            end

            ST_STORE: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                if (mem_ready) begin
                    nxt_d.st = ST_GATE;
                end
            end

            ST_STOP: begin
                nxt_d.st = ST_STOP;
            end

            default: begin
                nxt_d.st = ST_GATE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_GATE;
            cur_q.pc   <= start_addr;
            cur_q.ir   <= '0;
            cur_q.addr <= '0;
            cur_q.nzp  <= 3'b010;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign halted = (cur_q.st == ST_STOP);
    assign pc_out = cur_q.pc;
    assign nzp    = cur_q.nzp;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_ready) |=> (mem_en && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_en);

    // R7
    nzp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nzp) == 1);

    // R7
    store_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> $stable(nzp));

    // R2
    fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_FETCH && mem_ready) |=> (pc_out == $past(pc_out) + 16'd1));

    // R10
    step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_GATE && step_mode && !step_req) |=> !mem_en);

endmodule

// File: tb/seq16_core_bench.sv
module seq16_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] start_addr = 16'h3000;
    logic        step_mode = 1'b1;
    logic        step_req = 1'b0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = 16'h0000;
    logic        mem_ready = 1'b0;
    logic        halted;
    logic [15:0] pc_out;
    logic [2:0]  nzp;

    always #5 clk = ~clk;

    seq16_core u_seq16_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .step_mode  (step_mode),
        .step_req   (step_req),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .halted     (halted),
        .pc_out     (pc_out),
        .nzp        (nzp)
    );

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
        string       tag;
    } txn_t;

    txn_t        exp_q[$];
    logic [15:0] mem [int unsigned];
    int          n_chk = 0;
    int          n_fail = 0;
    int          txn_n = 0;
    int          wait_cnt = 0;
    logic        cap_we;
    logic [15:0] cap_addr, cap_wd;
    bit          finished = 0;

    function automatic logic [15:0] rd(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        mem[int'(a)] = d;
    endtask

    task automatic exf(input logic [15:0] a);
        exp_q.push_back('{1'b0, a, 16'h0000, "R2 fetch"});
    endtask

    task automatic exr(input logic [15:0] a, input string tag);
        exp_q.push_back('{1'b0, a, 16'h0000, tag});
    endtask

    task automatic exw(input logic [15:0] a, input logic [15:0] d, input string tag);
        exp_q.push_back('{1'b1, a, d, tag});
    endtask

    task automatic score(input logic we, input logic [15:0] a, input logic [15:0] d);
        txn_t e;
        if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 unexpected access actual=%h expected=none", a);
        end else begin
            e = exp_q.pop_front();
            chk({e.tag, " addr"}, a, e.addr);
            chk({e.tag, " dir"}, {15'd0, we}, {15'd0, e.we});
            if (e.we) chk({e.tag, " data"}, d, e.data);
        end
    endtask

    // memory model and monitor, both away from the rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            if (cap_we) mem[int'(cap_addr)] = cap_wd;
            score(cap_we, cap_addr, cap_wd);
            txn_n++;
        end else if (mem_en) begin
            if (wait_cnt >= (txn_n % 3)) begin
                cap_we    = mem_we;
                cap_addr  = mem_addr;
                cap_wd    = mem_wdata;
                mem_rdata = rd(mem_addr);
                mem_ready = 1'b1;
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    task automatic step_one();
        @(negedge clk) step_req = 1'b1;
        @(negedge clk) step_req = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic count_quiet(input int n, output int busy);
        busy = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mem_en) busy++;
        end
    endtask

    initial begin
        int busy;
        // program A at x3000
        poke(16'h3000, 16'h1230); poke(16'h3001, 16'h1427);
        poke(16'h3002, 16'h1642); poke(16'h3003, 16'h58EF);
        poke(16'h3004, 16'h9B3F); poke(16'h3005, 16'h7ABE);
        poke(16'h3006, 16'hEC09); poke(16'h3007, 16'hB608);
        poke(16'h3008, 16'h2E08); poke(16'h3009, 16'hA008);
        poke(16'h300A, 16'h6383); poke(16'h300B, 16'h2405);
        poke(16'h300C, 16'h7184); poke(16'h300D, 16'h3207);
        poke(16'h300E, 16'h3E07); poke(16'h300F, 16'hF025);
        poke(16'h3010, 16'h4000); poke(16'h3011, 16'h0000);
        poke(16'h3012, 16'h4000); poke(16'h3013, 16'hABCD);

        exf(16'h3000); exf(16'h3001); exf(16'h3002); exf(16'h3003);
        exf(16'h3004); exf(16'h3005);
        exw(16'h0005, 16'hFFF8, "R3/R5 operate chain and base store");
        exf(16'h3006); exf(16'h3007);
        exr(16'h3010, "R6 pointer read");
        exw(16'h4000, 16'hFFF7, "R6 indirect store");
        exf(16'h3008); exr(16'h3011, "R4 pc-relative load");
        exf(16'h3009); exr(16'h3012, "R6 pointer read");
        exr(16'h4000, "R6 operand read");
        exf(16'h300A); exr(16'h3013, "R4/R5 address-load base");
        exf(16'h300B); exr(16'h3011, "R4 pc-relative load");
        exf(16'h300C); exw(16'h3014, 16'hFFF7, "R6 indirect load value");
        exf(16'h300D); exw(16'h3015, 16'hABCD, "R5 base load value");
        exf(16'h300E); exw(16'h3016, 16'h0000, "R4 zero load value");
        exf(16'h300F);

        repeat (3) @(negedge clk);
        chk("R1 pc in reset", pc_out, 16'h3000);
        chk("R1 halted in reset", {15'd0, halted}, 16'd0);
        chk("R1 nzp in reset", {13'd0, nzp}, 16'h0002);
        chk("R1 no request in reset", {15'd0, mem_en}, 16'd0);
        rst_n = 1'b1;
        count_quiet(20, busy);
        chk("R10 no fetch without step", busy[15:0], 16'd0);
        chk("R10 pc held without step", pc_out, 16'h3000);

        step_mode = 1'b0;
        wait (halted === 1'b1);
        @(negedge clk);
        chk("R9 pc after halt", pc_out, 16'h3010);
        chk("R7 stores keep zero flag", {13'd0, nzp}, 16'h0002);
        count_quiet(30, busy);
        chk("R9 quiet after halt", busy[15:0], 16'd0);
        chk("R2 all accesses seen", exp_q.size(), 16'd0);

        // sample program, single-stepped from x30F6
        poke(16'h30F6, 16'hE3FD); poke(16'h30F7, 16'h146E);
        poke(16'h30F8, 16'h35FB); poke(16'h30F9, 16'h54A0);
        poke(16'h30FA, 16'h14A5); poke(16'h30FB, 16'h744E);
        poke(16'h30FC, 16'hA7F7); poke(16'h30FD, 16'h3602);
        poke(16'h30FE, 16'hF025);
        exf(16'h30F6); exf(16'h30F7); exf(16'h30F8);
        exw(16'h30F4, 16'h3102, "R11 store of sum");
        exf(16'h30F9); exf(16'h30FA); exf(16'h30FB);
        exw(16'h3102, 16'h0005, "R11 base store");
        exf(16'h30FC);
        exr(16'h30F4, "R11 pointer read");
        exr(16'h3102, "R11 operand read");
        exf(16'h30FD);
        exw(16'h3100, 16'h0005, "R11 R3 readback");
        exf(16'h30FE);

        step_mode = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        start_addr = 16'h30F6;
        repeat (2) @(negedge clk);
        chk("R1 pc reload", pc_out, 16'h30F6);
        rst_n = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            step_one();
            chk("R10 one instruction per step", pc_out, 16'h30F6 + 16'(k));
            if (k == 3) chk("R7 store keeps positive", {13'd0, nzp}, 16'h0001);
            if (k == 4) chk("R7 zero after and", {13'd0, nzp}, 16'h0002);
        end
        chk("R11 pc after sample", pc_out, 16'h30FD);
        chk("R7 positive after indirect load", {13'd0, nzp}, 16'h0001);
        step_one();
        chk("R11 memory holds R3", rd(16'h3100), 16'h0005);
        chk("R11 memory at x3102", rd(16'h3102), 16'h0005);
        step_one();
        chk("R9 halted set", {15'd0, halted}, 16'd1);
        chk("R9 pc past halt", pc_out, 16'h30FF);
        @(negedge clk) step_req = 1'b1;
        @(negedge clk) step_req = 1'b0;
        count_quiet(30, busy);
        chk("R9 step ignored when halted", busy[15:0], 16'd0);
        chk("R9 pc frozen", pc_out, 16'h30FF);
        chk("R6 all accesses seen", exp_q.size(), 16'd0);
        summary();
    end

endmodule